// File: doc/BRIEF.md
# Bus Debug Trigger Sequencer

This block decides when a debug trigger fires. Three comparators outside the block send one-cycle match strobes, called A, B and C. An external range check sends two compare results: the address is at or above the lower bound, and the address is at or below the upper bound. A 4-bit mode field selects how these inputs combine into a trigger. The supported combinations are:

- a single comparator;
- an either-of condition;
- ordered sequences, where A must come first and B later;
- same-cycle logical conditions;
- inside-range and outside-range conditions.

An arm strobe starts a capture window. When the selected condition is met, the block emits a one-cycle trigger pulse and disarms. It then waits until it is armed again.

A status/control register holds three sticky match flags and the mode field. The flags record, since the last arming, whether A, B or C matched. Any write to the register clears the flags, and so does arming.

Top module: `dbg_trig_seq`

## Requirements
- R1: After synchronous reset, `trig_pulse`, `armed` and all of `reg_rdata` are 0.
- R2: `reg_rdata` is laid out as bit 7 = A flag, bit 6 = B flag, bit 5 = C flag, bit 4 = 0 and bits 3:0 = mode. A register write stores `reg_wdata[3:0]` as the mode. `reg_wdata[7:4]` are ignored.
- R3: `arm_wr` sets `armed` at the next edge and clears all flags and any recorded A occurrence. A match in that same cycle neither sets a flag nor fires.
- R4: While armed, each match strobe sets its own flag, and the flag stays set until it is cleared. While disarmed, the match inputs set no flag and fire nothing.
- R5: Any `reg_wr` clears all three flags, whatever data is written. If a match occurs in the same cycle, the clear wins.
- R6: When the condition holds in an armed cycle, `trig_pulse` is 1 for exactly the following cycle and `armed` drops at that same edge.
- R7: The basic modes fire on A, on B, or on either:
  - mode 0000 fires on A;
  - mode 0001 fires on A or B;
  - mode 0011 fires on B.
- R8: Modes 0010 and 0100 fire on a B strobe in a cycle strictly later than an armed A strobe. A B strobe before the A strobe, or in the same cycle, does not fire.
- R9: Mode 0101 fires when A and B are both high in the same cycle. Mode 0110 fires when A is high and B is low.
- R10: Mode 0111 fires when `addr_ge_lo` and `addr_le_hi` are both high. Mode 1000 fires when at least one of them is low.
- R11: Mode codes 1001 through 1111 read back as written but trigger as mode 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_a | input | 1 | Comparator A match strobe |
| match_b | input | 1 | Comparator B match strobe |
| match_c | input | 1 | Comparator C match strobe |
| addr_ge_lo | input | 1 | Address at or above lower bound |
| addr_le_hi | input | 1 | Address at or below upper bound |
| arm_wr | input | 1 | Arm strobe |
| reg_wr | input | 1 | Status/control register write enable |
| reg_wdata | input | 8 | Register write data |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| armed | output | 1 | High while the sequencer is armed |
| reg_rdata | output | 8 | Status/control register read value |

## Verification
The assertions assume that `arm_wr` and `reg_wr` are one-cycle strobes. They also assume that the match and range inputs are valid in every cycle, and that nothing is left unknown after reset.

The stimulus drives every input at the falling edge, so each vector covers exactly one clock. It holds strobes for one cycle only. It re-arms after every trigger before expecting another, and it writes the mode only while the sequencer is disarmed. Mode 0100 is the one exception: there a write is deliberately made while armed, to show that the clear takes priority.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int MODE_W = 4;
  localparam int FLAG_N = 3;
  localparam int REG_W  = 8;

  typedef enum logic [MODE_W-1:0] {
    TM_A_ONLY    = 4'd0,
    TM_A_OR_B    = 4'd1,
    TM_A_THEN_B  = 4'd2,
    TM_B_ONLY    = 4'd3,
    TM_A_THEN_EB = 4'd4,
    TM_A_AND_B   = 4'd5,
    TM_A_NOT_B   = 4'd6,
    TM_IN_RANGE  = 4'd7,
    TM_OUT_RANGE = 4'd8
  } trig_mode_e;
endpackage

// File: rtl/trig_mode_decode.sv
module trig_mode_decode
  import dbg_trig_pkg::*;
(
  input  logic [MODE_W-1:0] mode_raw,
  output trig_mode_e        mode
);
  localparam logic [MODE_W-1:0] LAST_CODE = MODE_W'(TM_OUT_RANGE);

  always_comb begin
    if (mode_raw > LAST_CODE) mode = TM_A_ONLY;
    else                      mode = trig_mode_e'(mode_raw);
  end
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import dbg_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arm_wr,
  input  trig_mode_e mode,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       ge_lo,
  input  logic       le_hi,
  output logic       armed,
  output logic       trig_pulse
);
  logic seen_a;
  logic cond;
  logic in_rng;

  assign in_rng = ge_lo & le_hi;

  always_comb begin
    unique case (mode)
      TM_A_OR_B:    cond = hit_a | hit_b;
      TM_A_THEN_B,
      TM_A_THEN_EB: cond = seen_a & hit_b;
      TM_B_ONLY:    cond = hit_b;
      TM_A_AND_B:   cond = hit_a & hit_b;
      TM_A_NOT_B:   cond = hit_a & ~hit_b;
      TM_IN_RANGE:  cond = in_rng;
      TM_OUT_RANGE: cond = ~in_rng;
      default:      cond = hit_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      seen_a     <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= 1'b0;
      if (arm_wr) begin
        armed  <= 1'b1;
        seen_a <= 1'b0;
      end else if (armed) begin
        if (cond) begin
          trig_pulse <= 1'b1;
          armed      <= 1'b0;
          seen_a     <= 1'b0;
        end else if (hit_a) begin
          seen_a <= 1'b1;
        end
      end
    end
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    trig_pulse |=> !trig_pulse);
  // R6
  disarm_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_pulse) |-> !armed);
  // R3
  arm_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
    arm_wr |=> (armed && !trig_pulse));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!armed && !arm_wr) |=> !trig_pulse);
endmodule

// File: rtl/trig_status.sv
module trig_status
  import dbg_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_wr,
  input  logic              reg_wr,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              armed,
  input  logic [FLAG_N-1:0] hits,
  output logic [FLAG_N-1:0] flags,
  output logic [MODE_W-1:0] mode_raw
);
  logic clr;
  assign clr = arm_wr | reg_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      mode_raw <= '0;
    end else begin
      if (clr)        flags <= '0;
      else if (armed) flags <= flags | hits;
      if (reg_wr) mode_raw <= wr_mode;
    end
  end

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flags == '0));
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  // R4
  disarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !armed) |=> $stable(flags));
  // R2
  mode_store_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (mode_raw == $past(wr_mode)));
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             match_a,
  input  logic             match_b,
  input  logic             match_c,
  input  logic             addr_ge_lo,
  input  logic             addr_le_hi,
  input  logic             arm_wr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             trig_pulse,
  output logic             armed,
  output logic [REG_W-1:0] reg_rdata
);
  localparam int PAD_W = REG_W - FLAG_N - MODE_W;

  logic [MODE_W-1:0]       mode_raw;
  logic [FLAG_N-1:0]       flags;
  trig_mode_e              mode;
  logic [REG_W-MODE_W-1:0] unused_wdata_hi;

  assign unused_wdata_hi = reg_wdata[REG_W-1:MODE_W];

  trig_mode_decode u_dec (
    .mode_raw (mode_raw),
    .mode     (mode)
  );

  trig_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .arm_wr     (arm_wr),
    .mode       (mode),
    .hit_a      (match_a),
    .hit_b      (match_b),
    .ge_lo      (addr_ge_lo),
    .le_hi      (addr_le_hi),
    .armed      (armed),
    .trig_pulse (trig_pulse)
  );

  trig_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .arm_wr   (arm_wr),
    .reg_wr   (reg_wr),
    .wr_mode  (reg_wdata[MODE_W-1:0]),
    .armed    (armed),
    .hits     ({match_a, match_b, match_c}),
    .flags    (flags),
    .mode_raw (mode_raw)
  );

  assign reg_rdata = {flags, {PAD_W{1'b0}}, mode_raw};
endmodule

// File: tb/sim_dbg_trig_seq.sv
module sim_dbg_trig_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       match_a, match_b, match_c, addr_ge_lo, addr_le_hi;
  logic       arm_wr, reg_wr;
  logic [7:0] reg_wdata;
  logic       trig_pulse, armed;
  logic [7:0] reg_rdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dbg_trig_seq u0 (
    .clk(clk), .rst(rst), .match_a(match_a), .match_b(match_b),
    .match_c(match_c), .addr_ge_lo(addr_ge_lo), .addr_le_hi(addr_le_hi),
    .arm_wr(arm_wr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .trig_pulse(trig_pulse), .armed(armed), .reg_rdata(reg_rdata)
  );

  // vector: arm | wr | mode[4] | a b c ge le | exp_trig | exp_armed | exp_flags[3]
  localparam int NV = 51;
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'b0_1_0000_00000_0_0_000, // R7 mode A only
    16'b0_0_0000_10000_0_0_000, // R4 disarmed match ignored
    16'b1_0_0000_00000_0_1_000, // R3 arm
    16'b0_0_0000_01100_0_1_011, // R4 B,C flags
    16'b0_0_0000_10000_1_0_111, // R7 fire on A
    16'b0_0_0000_00000_0_0_111, // R6 single pulse, sticky
    16'b0_1_0010_00000_0_0_000, // R5 write clears
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_01000_0_1_010, // R8 B before A
    16'b0_0_0000_11000_0_1_110, // R8 B with A
    16'b0_0_0000_01000_1_0_110, // R8 later B fires
    16'b0_1_0101_00000_0_0_000,
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_10000_0_1_100, // R9
    16'b0_0_0000_01000_0_1_110,
    16'b0_0_0000_11000_1_0_110, // R9 A and B
    16'b0_1_0110_00000_0_0_000,
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_11000_0_1_110, // R9 A with B: no fire
    16'b0_0_0000_10000_1_0_110, // R9 A and not B
    16'b0_1_0111_00000_0_0_000,
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_00010_0_1_000, // R10
    16'b0_0_0000_00011_1_0_000, // R10 inside
    16'b0_1_1000_00011_0_0_000,
    16'b1_0_0000_00011_0_1_000,
    16'b0_0_0000_00011_0_1_000, // R10
    16'b0_0_0000_00001_1_0_000, // R10 outside
    16'b0_1_1011_00000_0_0_000, // R11 reserved
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_01000_0_1_010, // R11
    16'b0_0_0000_10000_1_0_110, // R11 acts as A only
    16'b0_1_0001_00000_0_0_000,
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_01000_1_0_010, // R7 A or B
    16'b0_1_0011_00000_0_0_000,
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_10000_0_1_100, // R7
    16'b0_0_0000_01000_1_0_110, // R7 B only
    16'b0_1_0100_00000_0_0_000,
    16'b1_0_0000_00000_0_1_000,
    16'b0_0_0000_10000_0_1_100, // R8
    16'b0_0_0000_01000_1_0_110, // R8 A then event B
    16'b1_0_0000_00000_0_1_000, // R3 rearm clears
    16'b0_1_0100_10000_0_1_000, // R5 clear wins over A
    16'b0_0_0000_01000_1_0_010, // R8 A still recorded
    16'b1_0_0000_10000_0_1_000, // R3 A during arm ignored
    16'b0_0_0000_01000_0_1_010, // R3 no fire
    16'b0_0_0000_10000_0_1_110,
    16'b0_0_0000_01000_1_0_110,
    16'b0_0_0000_11100_0_0_110  // R4 disarmed ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    match_a = 0; match_b = 0; match_c = 0; addr_ge_lo = 0; addr_le_hi = 0;
    arm_wr = 0; reg_wr = 0; reg_wdata = 8'h00;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] cur_mode;
    cur_mode = 4'd0;
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 trig", {7'd0, trig_pulse}, 8'd0);
    check("R1 armed", {7'd0, armed}, 8'd0);
    check("R1 rdata", reg_rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      @(negedge clk);
      idle();
      arm_wr = v[15]; reg_wr = v[14]; reg_wdata = {4'hF, v[13:10]};
      match_a = v[9]; match_b = v[8]; match_c = v[7];
      addr_ge_lo = v[6]; addr_le_hi = v[5];
      if (v[14]) cur_mode = v[13:10];
      @(posedge clk);
      #5;
      check("R6 trig_pulse", {7'd0, trig_pulse}, {7'd0, v[4]});
      check("R6 armed", {7'd0, armed}, {7'd0, v[3]});
      check("R2 rdata", reg_rdata, {v[2:0], 1'b0, cur_mode});
    end

    // R2 write with all ones: bit 4 reads 0, flags stay clear
    @(negedge clk);
    idle();
    reg_wr = 1'b1; reg_wdata = 8'hFF;
    @(posedge clk); #5;
    check("R2 readback", reg_rdata, 8'h0F);

    // R1 reset mid-run after arming and flag setting
    @(negedge clk); idle(); reg_wr = 1'b1; reg_wdata = 8'h03;
    @(negedge clk); idle(); arm_wr = 1'b1;
    @(negedge clk); idle(); match_a = 1'b1; match_c = 1'b1;
    @(posedge clk); #5;
    check("R4 flags", reg_rdata, 8'hA3);
    @(negedge clk); idle(); rst = 1'b1;
    @(posedge clk); #5;
    check("R1 rdata after reset", reg_rdata, 8'h00);
    check("R1 armed after reset", {7'd0, armed}, 8'd0);
    @(negedge clk); rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule